// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge with Byte Lanes

This block connects a synchronous request bus to an external asynchronous static RAM with 256K words of 16 bits. A requester presents an address, write data, a two-bit byte enable and a read/write flag, and holds `req_valid` high. The bridge then drives the RAM's active-low chip select, output enable, write enable and per-byte selects. It sequences each access in whole clock cycles, so that the RAM's minimum access, strobe and bus-release times are met. It answers with a one-cycle `req_ready` pulse.

Every phase length is derived from timing parameters given in picoseconds, together with the clock period, and is rounded up to whole cycles. With the default 4 ns clock:

- A read holds the RAM pins active for 3 cycles and then captures the data.
- A write uses one setup cycle, a 2-cycle write-enable pulse and one release cycle.
- Each access is followed by a 2-cycle quiet turnaround, so the RAM's outputs and the bridge's drivers never overlap on the shared data bus.

Top module: `sram_bridge`

## Requirements
- R1: After reset, and whenever no access is in progress, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are all high, req_ready is low, and mem_we_n or mem_oe_n is never low while mem_cs_n is high.
- R2: A write stores only the lanes whose req_be bit is 1: req_be[0] selects bits 7:0 through mem_lb_n, and req_be[1] selects bits 15:8 through mem_ub_n, both active low. With req_be = 00, no bit of the RAM word changes.
- R3: A read returns, on rsp_rdata, the RAM word's enabled lanes. A lane whose req_be bit is 0 reads as zero and its RAM byte select stays high.
- R4: mem_we_n is low only while mem_cs_n is low and mem_oe_n is high, and mem_addr does not change while mem_we_n is low.
- R5: The write-enable pulse lasts exactly ceil(T_STROBE_PS/CLK_PS) cycles (2 by default). Write data is on mem_dq from the setup cycle until one cycle after mem_we_n rises.
- R6: Starting from idle, a read samples mem_dq only after chip select and output enable have been low for ceil(T_CYCLE_PS/CLK_PS) cycles (3 by default). For a read or a write, req_ready rises in the 4th cycle after the cycle in which the request is presented.
- R7: req_ready is high for exactly one cycle per access. On a read, rsp_rdata holds the captured word in that cycle and keeps it until the next read.
- R8: The bridge drives mem_dq only while mem_oe_n is high, and only after mem_oe_n has been high for at least ceil(T_HIZ_PS/CLK_PS) cycles.
- R9: After the ready cycle, chip select stays high for ceil(T_HIZ_PS/CLK_PS)+1 cycles (3 by default) before a waiting request starts. A request held back to back therefore gets req_ready 7 cycles after the previous one. Read-after-write and write-after-read to the same word return the merged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data, disabled lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | RAM lower byte select, active low |
| mem_ub_n | output | 1 | RAM upper byte select, active low |
| mem_dq | inout | 16 | Shared bidirectional RAM data bus |

## Verification
A phase sequencer stuck in a wrong state or with a wrong count shows up at the ports within one access. req_ready arrives in a cycle other than the fourth, the write-enable pulse has the wrong width, or the bench's RAM model hands back filler data because the capture came before three active cycles had passed. A wrong byte-enable latch shows up as a corrupted lane on the next read of that word. A driver enable that is out of step with output enable is caught in the cycle it happens: the bus value then differs from what the RAM model is driving.

// File: rtl/sram_bridge_pkg.sv
`timescale 1ns/1ps
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    PH_IDLE       = 3'd0,
    PH_RD_ACCESS  = 3'd1,
    PH_RD_CAPTURE = 3'd2,
    PH_WR_SETUP   = 3'd3,
    PH_WR_STROBE  = 3'd4,
    PH_WR_RELEASE = 3'd5,
    PH_TURNAROUND = 3'd6
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic lanes_on;
    logic drive;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_QUIET = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      lanes_on: 1'b0, drive: 1'b0};

  // Whole cycles covering a time, never fewer than one.
  function automatic int unsigned cycles_for(input int unsigned t_ps,
                                             input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n == 0) n = 1;
    return n;
  endfunction

  function automatic int unsigned max_of(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels held during each phase.
  function automatic pin_ctl_t pins_for(input phase_e ph);
    pin_ctl_t p;
    p = PINS_QUIET;
    case (ph)
      PH_RD_ACCESS: begin
        p.cs_n = 1'b0; p.oe_n = 1'b0; p.lanes_on = 1'b1;
      end
      PH_WR_SETUP: begin
        p.cs_n = 1'b0; p.lanes_on = 1'b1; p.drive = 1'b1;
      end
      PH_WR_STROBE: begin
        p.cs_n = 1'b0; p.we_n = 1'b0; p.lanes_on = 1'b1; p.drive = 1'b1;
      end
      PH_WR_RELEASE: begin
        p.drive = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
`timescale 1ns/1ps
module sram_phase_seq
  import sram_bridge_pkg::*;
#(
  parameter int unsigned RD_CYC = 3,
  parameter int unsigned SU_CYC = 1,
  parameter int unsigned WP_CYC = 2,
  parameter int unsigned TA_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   accept,
  output logic   capture
);

  localparam int unsigned MAX_CYC = max_of(max_of(RD_CYC, SU_CYC), max_of(WP_CYC, TA_CYC));
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] SU_LOAD = CNT_W'(SU_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = (phase_q == PH_IDLE) && req_valid;
  assign capture  = (phase_q == PH_RD_ACCESS) && cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            phase_d = PH_WR_SETUP;
            cnt_d   = SU_LOAD;
          end else begin
            phase_d = PH_RD_ACCESS;
            cnt_d   = RD_LOAD;
          end
        end
      end
      PH_RD_ACCESS: begin
        if (cnt_zero) phase_d = PH_RD_CAPTURE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      PH_WR_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_WR_STROBE;
          cnt_d   = WP_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WR_STROBE: begin
        if (cnt_zero) phase_d = PH_WR_RELEASE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      PH_RD_CAPTURE, PH_WR_RELEASE: begin
        phase_d = PH_TURNAROUND;
        cnt_d   = TA_LOAD;
      end
      PH_TURNAROUND: begin
        if (cnt_zero) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_lane_slice.sv
`timescale 1ns/1ps
module sram_lane_slice #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              en_in,
  input  logic [LANE_W-1:0] wdata_in,
  input  logic              lanes_on_d,
  input  logic              capture,
  input  logic [LANE_W-1:0] dq_in,
  output logic              sel_n,
  output logic [LANE_W-1:0] wdata_q,
  output logic [LANE_W-1:0] rdata_q
);

  logic en_q;
  logic en_nxt;

  assign en_nxt = load ? en_in : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      sel_n   <= 1'b1;
    end else begin
      if (load) begin
        en_q    <= en_in;
        wdata_q <= wdata_in;
      end
      sel_n <= ~(lanes_on_d & en_nxt);
      if (capture) rdata_q <= en_q ? dq_in : '0;
    end
  end

endmodule

// File: rtl/sram_bridge.sv
`timescale 1ns/1ps
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned LANE_W      = 8,
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned T_CYCLE_PS  = 12000,
  parameter int unsigned T_STROBE_PS = 8000,
  parameter int unsigned T_HIZ_PS    = 6000,
  parameter int unsigned T_SETUP_PS  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  input  logic [1:0]          req_be,
  output logic                req_ready,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_lb_n,
  output logic                mem_ub_n,
  inout  wire  [2*LANE_W-1:0] mem_dq
);

  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned RD_CYC = cycles_for(T_CYCLE_PS, CLK_PS);
  localparam int unsigned SU_CYC = cycles_for(T_SETUP_PS, CLK_PS);
  localparam int unsigned WP_CYC = cycles_for(T_STROBE_PS, CLK_PS);
  localparam int unsigned TA_CYC = cycles_for(T_HIZ_PS, CLK_PS);

  phase_e              phase_q, phase_d;
  logic                accept, capture;
  pin_ctl_t            pins_q, pins_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [LANES-1:0]    sel_n;
  logic [DATA_W-1:0]   wdata_bus;
  logic                dq_drive;

  sram_phase_seq #(
    .RD_CYC(RD_CYC), .SU_CYC(SU_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .phase_q(phase_q), .phase_d(phase_d), .accept(accept), .capture(capture)
  );

  assign pins_d = pins_for(phase_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= PINS_QUIET;
      addr_q <= '0;
    end else begin
      pins_q <= pins_d;
      if (accept) addr_q <= req_addr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_slice #(.LANE_W(LANE_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(accept), .en_in(req_be[g]),
      .wdata_in(req_wdata[g*LANE_W +: LANE_W]), .lanes_on_d(pins_d.lanes_on),
      .capture(capture), .dq_in(mem_dq[g*LANE_W +: LANE_W]), .sel_n(sel_n[g]),
      .wdata_q(wdata_bus[g*LANE_W +: LANE_W]), .rdata_q(rsp_rdata[g*LANE_W +: LANE_W])
    );
  end

  assign dq_drive  = pins_q.drive;
  assign mem_dq    = dq_drive ? wdata_bus : {DATA_W{1'bz}};
  assign mem_addr  = addr_q;
  assign mem_cs_n  = pins_q.cs_n;
  assign mem_oe_n  = pins_q.oe_n;
  assign mem_we_n  = pins_q.we_n;
  assign mem_lb_n  = sel_n[0];
  assign mem_ub_n  = sel_n[LANES-1];
  assign req_ready = (phase_q == PH_RD_CAPTURE) || (phase_q == PH_WR_RELEASE);

endmodule

// File: rtl/sram_bridge_chk.sv
`timescale 1ns/1ps
module sram_bridge_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned TA_CYC = 2,
  parameter int unsigned WP_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              drive,
  input logic              ready,
  input logic [ADDR_W-1:0] addr
);

  logic [7:0] oe_hi_cnt;
  logic [7:0] we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= 8'hFF;
      we_lo_cnt <= 8'h00;
    end else begin
      if (!oe_n)                oe_hi_cnt <= 8'h00;
      else if (oe_hi_cnt != 8'hFF) oe_hi_cnt <= oe_hi_cnt + 8'h01;
      if (we_n)                 we_lo_cnt <= 8'h00;
      else if (we_lo_cnt != 8'hFF) we_lo_cnt <= we_lo_cnt + 8'h01;
    end
  end

  // R1
  quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (we_n && oe_n));

  // R4
  strobe_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && oe_n));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(addr));

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo_cnt == 8'(WP_CYC)));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> oe_n);

  // R8
  drive_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> (oe_hi_cnt >= 8'(TA_CYC)));

endmodule

bind sram_bridge sram_bridge_chk #(
  .ADDR_W(ADDR_W), .TA_CYC(TA_CYC), .WP_CYC(WP_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
  .drive(dq_drive), .ready(req_ready), .addr(mem_addr)
);

// File: tb/test_sram_bridge.sv
`timescale 1ns/1ps
module test_sram_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  wire  [15:0] mem_dq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  sram_bridge i_sram_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq(mem_dq)
  );

  // ---------------- behavioural RAM ----------------
  logic [15:0] ram     [logic [17:0]];
  logic [15:0] exp_mem [logic [17:0]];
  logic [15:0] ram_val = 16'hDEAD;
  int          rd_cnt  = 0;
  int          we_run  = 0;
  int          last_pulse = 0;
  int          r4_viol = 0;
  int          r8_viol = 0;
  logic [17:0] strobe_addr = '0;
  logic        rd_active;

  function automatic logic [15:0] init_word(input logic [17:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[17:16], 14'h0};
  endfunction

  function automatic logic [15:0] ram_get(input logic [17:0] a);
    return ram.exists(a) ? ram[a] : init_word(a);
  endfunction

  function automatic logic [15:0] exp_get(input logic [17:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : init_word(a);
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old_w,
                                        input logic [15:0] new_w,
                                        input logic [1:0] be);
    return (old_w & ~lane_mask(be)) | (new_w & lane_mask(be));
  endfunction

  assign rd_active    = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq[7:0]  = (rd_active && !mem_lb_n) ? ram_val[7:0]  : 8'hzz;
  assign mem_dq[15:8] = (rd_active && !mem_ub_n) ? ram_val[15:8] : 8'hzz;

  always @(negedge clk) begin
    logic [15:0] w;
    // R8: bus must carry exactly what the RAM drives
    if (rd_active && !mem_lb_n && mem_dq[7:0] !== ram_val[7:0]) r8_viol++;
    if (rd_active && !mem_ub_n && mem_dq[15:8] !== ram_val[15:8]) r8_viol++;
    // data valid only after three active read cycles
    if (rd_active) begin
      rd_cnt  = rd_cnt + 1;
      ram_val = (rd_cnt >= 3) ? ram_get(mem_addr) : 16'hDEAD;
    end else begin
      rd_cnt  = 0;
      ram_val = 16'hDEAD;
    end
    // write strobe: store selected lanes
    if (!mem_we_n) begin
      if (mem_cs_n || !mem_oe_n) r4_viol++;
      if (we_run == 0) strobe_addr = mem_addr;
      else if (mem_addr !== strobe_addr) r4_viol++;
      we_run = we_run + 1;
      if (!mem_cs_n) begin
        w = ram_get(mem_addr);
        if (!mem_lb_n) w[7:0]  = mem_dq[7:0];
        if (!mem_ub_n) w[15:8] = mem_dq[15:8];
        ram[mem_addr] = w;
      end
    end else begin
      if (we_run != 0) last_pulse = we_run;
      we_run = 0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; returns at the negedge where req_ready is seen.
  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be, output logic [15:0] rd, output int lat);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_ready && lat < 60);
    rd = rsp_rdata;
    req_valid = 1'b0;
    if (wr) exp_mem[a] = merge(exp_get(a), d, be);
  endtask

  task automatic check_quiet(input string req);
    check({mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, req_ready} == 6'b111110,
          req, {26'h0, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, req_ready},
          32'h3E);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] rd;
    logic [15:0] e;
    int lat;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);

    repeat (3) @(negedge clk);
    check_quiet("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_quiet("R1 idle after reset");

    // full write then read, latency from idle
    access(1'b1, 18'h00005, 16'h1234, 2'b11, rd, lat);
    check(lat == 4, "R6 write latency", lat, 4);
    @(negedge clk);
    check(!req_ready, "R7 ready one cycle", req_ready, 0);
    check(last_pulse == 2, "R5 strobe width", last_pulse, 2);
    repeat (4) @(negedge clk);
    check_quiet("R1 idle between");
    access(1'b0, 18'h00005, 16'h0, 2'b11, rd, lat);
    check(lat == 4, "R6 read latency", lat, 4);
    check(rd == 16'h1234, "R3 full read", rd, 16'h1234);
    @(negedge clk);
    check(!req_ready, "R7 ready one cycle after read", req_ready, 0);
    check(rsp_rdata == 16'h1234, "R7 read data held", rsp_rdata, 16'h1234);

    // lane merges
    repeat (4) @(negedge clk);
    access(1'b1, 18'h00005, 16'hAB00, 2'b10, rd, lat);
    repeat (4) @(negedge clk);
    access(1'b1, 18'h00005, 16'h00CD, 2'b01, rd, lat);
    repeat (4) @(negedge clk);
    access(1'b0, 18'h00005, 16'h0, 2'b11, rd, lat);
    check(rd == 16'hABCD, "R2 lane merge", rd, 16'hABCD);

    // write with no lanes
    repeat (4) @(negedge clk);
    access(1'b1, 18'h00005, 16'h5555, 2'b00, rd, lat);
    repeat (4) @(negedge clk);
    access(1'b0, 18'h00005, 16'h0, 2'b11, rd, lat);
    check(rd == 16'hABCD, "R2 empty byte enable", rd, 16'hABCD);

    // partial reads
    repeat (4) @(negedge clk);
    access(1'b0, 18'h00005, 16'h0, 2'b01, rd, lat);
    check(rd == 16'h00CD, "R3 lower lane read", rd, 16'h00CD);
    repeat (4) @(negedge clk);
    access(1'b0, 18'h00005, 16'h0, 2'b10, rd, lat);
    check(rd == 16'hAB00, "R3 upper lane read", rd, 16'hAB00);
    repeat (4) @(negedge clk);
    access(1'b0, 18'h00005, 16'h0, 2'b00, rd, lat);
    check(rd == 16'h0000, "R3 no lane read", rd, 16'h0000);

    // top address, unwritten word
    repeat (4) @(negedge clk);
    e = init_word(18'h3FFFF);
    access(1'b0, 18'h3FFFF, 16'h0, 2'b11, rd, lat);
    check(rd == e, "R3 unwritten top word", rd, e);
    repeat (4) @(negedge clk);
    access(1'b1, 18'h3FFFF, 16'hFEED, 2'b11, rd, lat);
    // R9 read-after-write back to back
    access(1'b0, 18'h3FFFF, 16'h0, 2'b11, rd, lat);
    check(lat == 7, "R9 back-to-back latency", lat, 7);
    check(rd == 16'hFEED, "R9 read after write", rd, 16'hFEED);
    // R9 write-after-read back to back, then read
    access(1'b1, 18'h3FFFF, 16'h0011, 2'b01, rd, lat);
    check(lat == 7, "R9 write after read latency", lat, 7);
    access(1'b0, 18'h3FFFF, 16'h0, 2'b11, rd, lat);
    check(rd == 16'hFE11, "R9 write after read data", rd, 16'hFE11);

    // constrained random mix
    for (int i = 0; i < 300; i++) begin
      bit          wr;
      logic [17:0] a;
      logic [1:0]  be;
      logic [15:0] d;
      int          gap;
      wr  = 1'($urandom_range(0, 1));
      a   = {($urandom_range(0, 3) == 0) ? 2'b11 : 2'b00, 11'h0, 5'($urandom_range(0, 31))};
      be  = 2'($urandom_range(0, 3));
      d   = 16'($urandom);
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      e = exp_get(a) & lane_mask(be);
      access(wr, a, d, be, rd, lat);
      if (!wr) check(rd == e, be == 2'b11 ? "R3 random read" : "R2 random lane read", rd, e);
    end

    repeat (6) @(negedge clk);
    check_quiet("R1 idle at end");
    check(r4_viol == 0, "R4 strobe address and select", r4_viol, 0);
    check(r8_viol == 0, "R8 bus contention", r8_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule